// File: doc/BRIEF.md
# OTP Shadow Loader with CRC-8 Integrity Check

This block looks after a 128-byte one-time-programmable (OTP) array and the shadow registers that hold the live copy of its contents. When reset is released, the block reads every OTP byte in ascending order through a read port with one cycle of latency. It writes each byte into the shadow registers through a write port.

While the bytes stream in, a CRC-8 is accumulated over bytes 0 to 57. The result is compared with the check byte held at address 63. A mismatch raises a fallback flag, which tells downstream logic to use default values for the trimmed parameters, and it also sets a sticky failure flag.

After startup the block re-verifies the OTP contents. This happens periodically, on a programmable idle interval, and once whenever control-port mode is left. A verify pass reads OTP bytes 0 to 63 only and does not touch the shadows, so user edits survive a passing check. A failing check reloads all 128 shadow bytes from OTP, which discards the edits. Checking can be suppressed by a disable input or by control-port mode.

Top module: `otp_shadow_loader`

## Requirements
- R1: After reset is released, all 128 shadow bytes are written in ascending address order with the OTP content of the same address. `ready` rises after the last write and stays high until the next reset.
- R2: The CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07). It starts from 0x00 and takes each byte most-significant bit first, over addresses 0 to 57 in ascending order. It is compared with the byte at address 63. At the end of the startup upload, a mismatch sets `useDefaults` and `crcFail`, and a match leaves both at 0.
- R3: OTP bytes at addresses 58 to 62 and 64 to 127 have no effect on the outcome of any check.
- R4: With checking enabled and `checkInterval` = N > 0, a verify pass starts after N consecutive idle cycles. With N = 0 no periodic pass starts.
- R5: A verify pass whose CRC matches performs no shadow write, so shadow contents changed by the user are kept.
- R6: A verify pass whose CRC mismatches sets `crcFail` and rewrites all 128 shadow bytes from OTP. After that reload, `useDefaults` reflects the reload's own check.
- R7: A 1-to-0 transition of `ctrlPortMode` while `crcDisable` is 0 causes one verify pass.
- R8: While `crcDisable` or `ctrlPortMode` is 1, no verify pass or reload starts. A startup mismatch under these conditions leaves `useDefaults` and `crcFail` at 0. The upload itself still completes.
- R9: `crcFail` stays set until a cycle with `statusRead` high clears it. A new failure in the same cycle wins over the clear.
- R10: While reset is asserted, `ready`, `useDefaults`, `crcFail`, `otpRdEn` and `shWrEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| otpRdEn | output | 1 | OTP read request for the address on `otpAddr` |
| otpAddr | output | 7 | OTP byte address |
| otpData | input | 8 | OTP read data, valid one cycle after the request |
| shWrEn | output | 1 | Shadow register write strobe |
| shWrAddr | output | 7 | Shadow register address |
| shWrData | output | 8 | Shadow register write data |
| crcDisable | input | 1 | Suppresses all checking when 1 |
| ctrlPortMode | input | 1 | Control-port mode active; suppresses checking, and its exit triggers a check |
| checkInterval | input | 16 | Idle cycles between periodic checks; 0 disables periodic checks |
| statusRead | input | 1 | Clears `crcFail` |
| ready | output | 1 | Startup upload complete |
| useDefaults | output | 1 | Use fallback defaults, because the last upload failed its CRC |
| crcFail | output | 1 | Sticky CRC failure flag |

## Verification
Because a verify pass is invisible at the ports when it matches, most wrong internal states show up as shadow-write bursts that should not happen, or as missing ones. A CRC register with a wrong polynomial, seed, bit order or address window shows up as `useDefaults` set after a clean startup of about 130 cycles. The same faults show up as a reload burst when an out-of-range byte is corrupted, or as no reload when an in-range byte is corrupted, within about 200 cycles of the trigger. A wrong interval counter moves the reload burst before or after the window N to N+200 cycles. A lost control-port exit leaves a corrupted array without any reload.

// File: rtl/otp_shadow_pkg.sv
package otp_shadow_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

  // strobes from control to datapath
  typedef struct packed {
    logic start;  // begin a pass at address 0
    logic copy;   // pass writes shadows and covers the whole array
  } passCmd_t;

  typedef enum logic [1:0] {
    S_BOOT,
    S_LOAD,
    S_CHECK,
    S_IDLE
  } loaderState_t;

  // one byte through the serial LFSR, MSB first
  function automatic logic [BYTE_W-1:0] crcByte(input logic [BYTE_W-1:0] crcIn,
                                                input logic [BYTE_W-1:0] din);
    logic [BYTE_W-1:0] c;
    logic fb;
    c = crcIn;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[BYTE_W-1] ^ din[i];
      c  = {c[BYTE_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/otp_shadow_dp.sv
module otp_shadow_dp
  import otp_shadow_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int CRC_END = 57,
  parameter int CRC_AT  = 63
) (
  input  logic                clk,
  input  logic                rstN,
  input  passCmd_t            cmd,
  output logic                otpRdEn,
  output logic [ADDR_W-1:0]   otpAddr,
  input  logic [BYTE_W-1:0]   otpData,
  output logic                shWrEn,
  output logic [ADDR_W-1:0]   shWrAddr,
  output logic [BYTE_W-1:0]   shWrData,
  output logic                passDone,
  output logic                crcMatch
);

  localparam int LAST_ALL = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W-1:0] LAST_FULL = ADDR_W'(LAST_ALL);
  localparam logic [ADDR_W-1:0] LAST_CHK  = ADDR_W'(CRC_AT);
  localparam logic [ADDR_W-1:0] END_SPAN  = ADDR_W'(CRC_END);

  logic              run, validQ, copyQ, matchQ;
  logic [ADDR_W-1:0] rdAddr, addrQ;
  logic [BYTE_W-1:0] crcQ;
  logic [ADDR_W-1:0] lastAddr;

  assign lastAddr = copyQ ? LAST_FULL : LAST_CHK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run    <= 1'b0;
      validQ <= 1'b0;
      copyQ  <= 1'b0;
      matchQ <= 1'b0;
      rdAddr <= '0;
      addrQ  <= '0;
      crcQ   <= '0;
    end else begin
      validQ <= run;
      if (run) begin
        addrQ  <= rdAddr;
        rdAddr <= rdAddr + 1'b1;
        if (rdAddr == lastAddr) run <= 1'b0;
      end
      if (validQ && addrQ <= END_SPAN) crcQ <= crcByte(crcQ, otpData);
      if (validQ && addrQ == LAST_CHK) matchQ <= (crcQ == otpData);
      if (cmd.start) begin
        run    <= 1'b1;
        rdAddr <= '0;
        copyQ  <= cmd.copy;
        crcQ   <= '0;
      end
    end
  end

  assign otpRdEn  = run;
  assign otpAddr  = rdAddr;
  assign shWrEn   = validQ && copyQ;
  assign shWrAddr = addrQ;
  assign shWrData = otpData;
  assign passDone = validQ && (addrQ == lastAddr);
  assign crcMatch = (addrQ == LAST_CHK) ? (crcQ == otpData) : matchQ;

endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             crcDisable,
  input  logic             ctrlPortMode,
  input  logic [CNT_W-1:0] checkInterval,
  input  logic             statusRead,
  input  logic             passDone,
  input  logic             crcMatch,
  output passCmd_t         cmd,
  output logic             ready,
  output logic             useDefaults,
  output logic             crcFail
);

  loaderState_t     state;
  logic [CNT_W-1:0] idleCnt;
  logic             cpQ, cpPend;
  logic             checkOn, cpExit, periodicHit, startCheck, failNow;

  assign checkOn     = !crcDisable && !ctrlPortMode;
  assign cpExit      = cpQ && !ctrlPortMode;
  assign periodicHit = (checkInterval != '0) && (idleCnt == checkInterval - 1'b1);
  assign startCheck  = (state == S_IDLE) && checkOn && (periodicHit || cpPend);
  assign failNow     = passDone && checkOn && !crcMatch;

  always_comb begin
    cmd.start = (state == S_BOOT) || startCheck || (state == S_CHECK && failNow);
    cmd.copy  = (state != S_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_BOOT;
      idleCnt     <= '0;
      cpQ         <= 1'b0;
      cpPend      <= 1'b0;
      ready       <= 1'b0;
      useDefaults <= 1'b0;
      crcFail     <= 1'b0;
    end else begin
      cpQ    <= ctrlPortMode;
      cpPend <= (cpPend && !startCheck) || (cpExit && !crcDisable);

      if (state == S_IDLE && checkOn && checkInterval != '0 && !startCheck)
        idleCnt <= idleCnt + 1'b1;
      else
        idleCnt <= '0;

      if (failNow) crcFail <= 1'b1;
      else if (statusRead) crcFail <= 1'b0;

      unique case (state)
        S_BOOT:  state <= S_LOAD;
        S_LOAD:  if (passDone) begin
                   ready       <= 1'b1;
                   useDefaults <= failNow;
                   state       <= S_IDLE;
                 end
        S_CHECK: if (passDone) state <= failNow ? S_LOAD : S_IDLE;
        S_IDLE:  if (startCheck) state <= S_CHECK;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otp_shadow_loader.sv
module otp_shadow_loader
  import otp_shadow_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int CRC_END = 57,
  parameter int CRC_AT  = 63,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              otpRdEn,
  output logic [ADDR_W-1:0] otpAddr,
  input  logic [7:0]        otpData,
  output logic              shWrEn,
  output logic [ADDR_W-1:0] shWrAddr,
  output logic [7:0]        shWrData,
  input  logic              crcDisable,
  input  logic              ctrlPortMode,
  input  logic [CNT_W-1:0]  checkInterval,
  input  logic              statusRead,
  output logic              ready,
  output logic              useDefaults,
  output logic              crcFail
);

  passCmd_t cmd;
  logic     passDone, crcMatch;

  otp_shadow_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .crcDisable(crcDisable), .ctrlPortMode(ctrlPortMode),
    .checkInterval(checkInterval), .statusRead(statusRead),
    .passDone(passDone), .crcMatch(crcMatch), .cmd(cmd),
    .ready(ready), .useDefaults(useDefaults), .crcFail(crcFail)
  );

  otp_shadow_dp #(.ADDR_W(ADDR_W), .CRC_END(CRC_END), .CRC_AT(CRC_AT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .otpRdEn(otpRdEn), .otpAddr(otpAddr), .otpData(otpData),
    .shWrEn(shWrEn), .shWrAddr(shWrAddr), .shWrData(shWrData),
    .passDone(passDone), .crcMatch(crcMatch)
  );

endmodule

// File: rtl/otp_shadow_loader_chk.sv
module otp_shadow_loader_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              otpRdEn,
  input logic              shWrEn,
  input logic [ADDR_W-1:0] shWrAddr,
  input logic              crcDisable,
  input logic              ctrlPortMode,
  input logic              statusRead,
  input logic              ready,
  input logic              useDefaults,
  input logic              crcFail
);

  // R1: back-to-back shadow writes walk upward one address at a time
  a_r1_seq_addr: assert property (@(posedge clk) disable iff (!rstN)
    shWrEn && $past(shWrEn) |-> shWrAddr == $past(shWrAddr) + 1'b1);

  // R1: ready holds once raised
  a_r1_ready_hold: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R2: the fallback flag only moves right after the final shadow write
  a_r2_defaults_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(useDefaults) |-> $past(shWrEn) && ($past(shWrAddr) == '1));

  // R8: a post-startup pass never starts while checking is suppressed
  a_r8_no_pass_when_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(otpRdEn) && $past(ready) |-> !$past(crcDisable) && !$past(ctrlPortMode));

  // R9: failure flag is sticky until read
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    crcFail && !statusRead |=> crcFail);

endmodule

bind otp_shadow_loader otp_shadow_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .otpRdEn(otpRdEn), .shWrEn(shWrEn),
  .shWrAddr(shWrAddr), .crcDisable(crcDisable), .ctrlPortMode(ctrlPortMode),
  .statusRead(statusRead), .ready(ready), .useDefaults(useDefaults),
  .crcFail(crcFail)
);

// File: tb/otp_shadow_loader_bench.sv
`timescale 1ns/1ps
module otp_shadow_loader_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        otpRdEn, shWrEn, ready, useDefaults, crcFail;
  logic [6:0]  otpAddr, shWrAddr;
  logic [7:0]  otpData, shWrData;
  logic        crcDisable = 1'b0, ctrlPortMode = 1'b0, statusRead = 1'b0;
  logic [15:0] checkInterval = '0;

  logic [7:0]  otpMem [128];
  logic [7:0]  shadow [128];
  logic        editEn = 1'b0, cntClr = 1'b0;
  logic [6:0]  editAddr = '0;
  logic [7:0]  editData = '0;
  int          wrCount = 0;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  otp_shadow_loader u_otp_shadow_loader (
    .clk(clk), .rstN(rstN), .otpRdEn(otpRdEn), .otpAddr(otpAddr), .otpData(otpData),
    .shWrEn(shWrEn), .shWrAddr(shWrAddr), .shWrData(shWrData),
    .crcDisable(crcDisable), .ctrlPortMode(ctrlPortMode), .checkInterval(checkInterval),
    .statusRead(statusRead), .ready(ready), .useDefaults(useDefaults), .crcFail(crcFail)
  );

  always @(posedge clk) otpData <= otpMem[otpAddr];

  always @(posedge clk) begin
    if (editEn) shadow[editAddr] <= editData;
    if (shWrEn) shadow[shWrAddr] <= shWrData;
    if (cntClr) wrCount <= 0;
    else if (shWrEn) wrCount <= wrCount + 1;
  end

  // {expect failure, corrupted address}
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'd0}, {1'b1, 8'd57}, {1'b0, 8'd58}, {1'b0, 8'd62},
    {1'b1, 8'd63}, {1'b0, 8'd64}, {1'b0, 8'd127}, {1'b1, 8'd30}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] refCrc();
    logic [7:0] c = 8'h00;
    for (int a = 0; a <= 57; a++) begin
      c ^= otpMem[a];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic fillOtp(input logic [7:0] seed, input bit good);
    for (int i = 0; i < 128; i++) otpMem[i] = 8'(i * 37) ^ seed;
    otpMem[63] = good ? refCrc() : ~refCrc();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cntClr = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!ready && !useDefaults && !crcFail && !otpRdEn && !shWrEn, "R10 reset outputs",
          {ready, useDefaults, crcFail, otpRdEn, shWrEn}, 0);
    cntClr = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
    check(ready, "R1 ready rises", ready, 1);
    @(negedge clk);
  endtask

  task automatic clearCount();
    @(negedge clk); cntClr = 1'b1;
    @(negedge clk); cntClr = 1'b0;
  endtask

  task automatic editShadow(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); editEn = 1'b1; editAddr = a; editData = d;
    @(negedge clk); editEn = 1'b0;
  endtask

  task automatic pulseCp();
    @(negedge clk); ctrlPortMode = 1'b1;
    repeat (3) @(negedge clk);
    ctrlPortMode = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    logic [7:0] edited;

    // table: corrupt one byte after startup, trigger a check via control-port exit
    for (int k = 0; k < NVEC; k++) begin
      bit fail;
      logic [6:0] ca;
      fail = VEC[k][8];
      ca = VEC[k][6:0];
      fillOtp(8'(k * 11 + 3), 1'b1);
      doReset();
      waitReady();
      clearCount();
      edited = ~otpMem[20];
      editShadow(7'd20, edited);
      otpMem[ca] = otpMem[ca] ^ 8'h5A;
      pulseCp();
      repeat (300) @(negedge clk);
      // R3 R6 R7: reload only when the corrupted byte is inside the checked window
      check(wrCount == (fail ? 128 : 0), "R3/R6 reload count", wrCount, fail ? 128 : 0);
      check(crcFail == fail, "R6 crcFail", crcFail, fail);
      check(useDefaults == fail, "R6 defaults after reload", useDefaults, fail);
      // R5 user edit kept on pass, R6 overwritten on fail
      check(shadow[20] == (fail ? otpMem[20] : edited), "R5/R6 edited shadow",
            shadow[20], fail ? otpMem[20] : edited);
    end

    // R1 R2: clean startup
    fillOtp(8'hC3, 1'b1);
    doReset();
    waitReady();
    bad = 0;
    for (int i = 0; i < 128; i++) if (shadow[i] !== otpMem[i]) bad++;
    check(bad == 0, "R1 shadow contents", bad, 0);
    check(wrCount == 128, "R1 upload writes", wrCount, 128);
    check(!useDefaults && !crcFail, "R2 clean startup flags", {useDefaults, crcFail}, 0);

    // R2 R9: bad check byte at startup
    fillOtp(8'h19, 1'b0);
    doReset();
    waitReady();
    check(useDefaults, "R2 startup mismatch defaults", useDefaults, 1);
    repeat (20) @(negedge clk);
    check(crcFail, "R9 crcFail sticky", crcFail, 1);
    statusRead = 1'b1; @(negedge clk); statusRead = 1'b0;
    @(negedge clk);
    check(!crcFail, "R9 cleared by read", crcFail, 0);
    check(useDefaults, "R9 read leaves defaults", useDefaults, 1);

    // R8: startup mismatch with checking disabled
    crcDisable = 1'b1;
    doReset();
    waitReady();
    check(!useDefaults && !crcFail, "R8 disabled startup", {useDefaults, crcFail}, 0);
    check(wrCount == 128, "R8 upload still done", wrCount, 128);
    crcDisable = 1'b0;

    // R8 R7: startup mismatch in control-port mode, then exit
    ctrlPortMode = 1'b1;
    doReset();
    waitReady();
    check(!useDefaults && !crcFail, "R8 cp-mode startup", {useDefaults, crcFail}, 0);
    @(negedge clk); ctrlPortMode = 1'b0;
    repeat (300) @(negedge clk);
    check(crcFail && useDefaults, "R7 exit triggers check", {crcFail, useDefaults}, 3);

    // R4 R5: periodic checks
    fillOtp(8'h77, 1'b1);
    doReset();
    waitReady();
    clearCount();
    editShadow(7'd5, 8'hA5 ^ otpMem[5]);
    checkInterval = 16'd60;
    repeat (400) @(negedge clk);
    check(wrCount == 0, "R5 passing periodic no writes", wrCount, 0);
    check(shadow[5] == (8'hA5 ^ otpMem[5]), "R5 edit kept", shadow[5], 8'hA5 ^ otpMem[5]);
    checkInterval = 16'd0;
    @(negedge clk);
    otpMem[10] = otpMem[10] ^ 8'h01;
    checkInterval = 16'd300;
    repeat (250) @(negedge clk);
    check(wrCount == 0, "R4 no pass before interval", wrCount, 0);
    repeat (350) @(negedge clk);
    check(wrCount == 128, "R4 one periodic reload", wrCount, 128);
    check(crcFail, "R4 periodic failure flagged", crcFail, 1);
    checkInterval = 16'd0;

    // R8 R7: control-port mode blocks periodic checks
    fillOtp(8'h2E, 1'b1);
    doReset();
    waitReady();
    clearCount();
    otpMem[3] = otpMem[3] ^ 8'h80;
    ctrlPortMode = 1'b1;
    checkInterval = 16'd50;
    repeat (400) @(negedge clk);
    check(wrCount == 0 && !crcFail, "R8 cp-mode blocks periodic", wrCount, 0);
    checkInterval = 16'd0;
    ctrlPortMode = 1'b0;
    repeat (300) @(negedge clk);
    check(wrCount == 128, "R7 exit reload", wrCount, 128);

    // R8: disable input blocks exit and periodic triggers
    fillOtp(8'h4D, 1'b1);
    doReset();
    waitReady();
    clearCount();
    otpMem[40] = otpMem[40] ^ 8'h10;
    crcDisable = 1'b1;
    pulseCp();
    checkInterval = 16'd50;
    repeat (400) @(negedge clk);
    check(wrCount == 0 && !crcFail, "R8 disable blocks checks", wrCount, 0);
    checkInterval = 16'd0;
    crcDisable = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule